// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is the general-purpose register store of a small pipelined processor. It holds thirty-two words. Two operand addresses can be looked up in the same clock cycle that a result is written back. Both lookups are purely combinational, so the operand values settle within the same cycle as their addresses. The write lands on the rising clock edge.

A lookup that names the entry being written in that same cycle sees the incoming value, not the old one. This write-through lets the memory stage retire its result while the decode stage reads it, with no separate forwarding path between them. Entry zero is hardwired: it always reads as zero and no write can change it.

The storage is split into identical narrow slices that sit side by side and share every address, so the data width grows by adding slices. While reset is held low, writes are blocked and write-through is off. Reset does not clear the stored words.

Top module: `rf_2r1w`

## Requirements
- R1: The two read ports are independent: each port returns the stored word at its own 5-bit address within the same cycle, with no clock edge between address and data.
- R2: When `wr_en` is high and `rst_n` is high at a rising edge, `wr_data` is stored at `wr_addr` and is returned by later reads of that address.
- R3: When `wr_en` is low at a rising edge, no stored word changes.
- R4: When `wr_en` is high, `rst_n` is high and a read address equals a nonzero `wr_addr`, that read port returns `wr_data` in the same cycle.
- R5: Address 0 always reads as zero on both ports. A write to address 0 is dropped and is not passed through.
- R6: When both read addresses are equal, both ports return identical data.
- R7: All 32 addresses (0 to 31) hold separate words, and a write to one address leaves every other address unchanged.
- R8: While `rst_n` is low, writes are blocked, write-through is disabled, and the stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| rd_addr_a | input | 5 | Address of read port A |
| rd_addr_b | input | 5 | Address of read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Word to write |
| rd_data_a | output | 32 | Data of read port A |
| rd_data_b | output | 32 | Data of read port B |

## Verification
The hardest case to reach is the same-cycle write-through: it lasts only the part of a cycle before the edge, and a wrong design can look correct if the bench samples after the edge. The stimulus therefore sets a write and a matching read address together, then samples between the input change and the next rising edge. It then re-reads the same entry after the edge to confirm the word was really stored. The bench also drives write-through aimed at entry zero, and a write attempted during reset while a read watches the target entry.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int unsigned RF_DEPTH   = 32;
    localparam int unsigned RF_DATA_W  = 32;
    localparam int unsigned RF_SLICE_W = 8;
    localparam int unsigned RF_ADDR_W  = $clog2(RF_DEPTH);
    localparam int unsigned RF_RD_PORTS = 2;

    typedef logic [RF_ADDR_W-1:0] rf_addr_t;
    typedef logic [RF_DATA_W-1:0] rf_word_t;

    typedef struct packed {
        logic     live;
        rf_addr_t addr;
        rf_word_t data;
    } rf_wr_req_t;
endpackage

// File: rtl/rf_slice.sv
module rf_slice #(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned SLICE_W = 8,
    parameter int unsigned NRD     = 2,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         wr_live,
    input  logic [AW-1:0]                wr_addr,
    input  logic [SLICE_W-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]       rd_addr,
    output logic [NRD-1:0][SLICE_W-1:0]  rd_data
);
    logic [SLICE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_live) begin
            cells[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = cells[rd_addr[p]];
    end
endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AW     = 5
) (
    input  logic [AW-1:0]     rd_addr,
    input  logic [DATA_W-1:0] stored,
    input  logic              wr_live,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    typedef enum logic [1:0] {
        SRC_ZERO   = 2'd0,
        SRC_THRU   = 2'd1,
        SRC_STORED = 2'd2
    } src_e;

    src_e src;

    always_comb begin
        if (rd_addr == '0) begin
            src = SRC_ZERO;
        end else if (wr_live && (wr_addr == rd_addr)) begin
            src = SRC_THRU;
        end else begin
            src = SRC_STORED;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ZERO:   rd_data = '0;
            SRC_THRU:   rd_data = wr_data;
            SRC_STORED: rd_data = stored;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w
    import rf_pkg::*;
#(
    parameter int unsigned DEPTH   = RF_DEPTH,
    parameter int unsigned DATA_W  = RF_DATA_W,
    parameter int unsigned SLICE_W = RF_SLICE_W,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned NSLICE = DATA_W / SLICE_W,
    localparam int unsigned NRD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr_a,
    input  logic [AW-1:0]     rd_addr_b,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    logic                         wr_live;
    logic [NRD-1:0][AW-1:0]       rd_addr;
    logic [NRD-1:0][DATA_W-1:0]   stored;
    logic [NRD-1:0][DATA_W-1:0]   rd_data;

    // Entry zero is never stored; reset blocks the write path.
    assign wr_live    = wr_en && rst_n && (wr_addr != '0);
    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        logic [NRD-1:0][SLICE_W-1:0] slice_rd;

        rf_slice #(
            .DEPTH  (DEPTH),
            .SLICE_W(SLICE_W),
            .NRD    (NRD)
        ) u_slice (
            .clk    (clk),
            .wr_live(wr_live),
            .wr_addr(wr_addr),
            .wr_data(wr_data[s*SLICE_W +: SLICE_W]),
            .rd_addr(rd_addr),
            .rd_data(slice_rd)
        );

        for (genvar p = 0; p < NRD; p++) begin : g_join
            assign stored[p][s*SLICE_W +: SLICE_W] = slice_rd[p];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_port
        rf_read_sel #(
            .DATA_W(DATA_W),
            .AW    (AW)
        ) u_sel (
            .rd_addr(rd_addr[p]),
            .stored (stored[p]),
            .wr_live(wr_live),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .rd_data(rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int unsigned AW     = 5,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     rd_addr_a,
    input logic [AW-1:0]     rd_addr_b,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);
    logic seen_edge;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    p_zero_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    p_zero_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    p_thru_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_data));

    p_thru_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data));

    p_same_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

    p_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(wr_en) && $past(wr_addr) != '0
         && rd_addr_a == $past(wr_addr) && !(wr_en && wr_addr == rd_addr_a))
        |-> (rd_data_a == $past(wr_data)));
endmodule

bind rf_2r1w rf_checker #(.AW(AW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_rf_2r1w.sv
`timescale 1ns/1ps
module sim_rf_2r1w;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data_a, rd_data_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rf_2r1w u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{we:1'b1, wa:5'd3,  wd:32'h0000_00A1, ra:5'd3,  rb:5'd0,  ea:32'h0000_00A1, eb:32'h0, req:8'd4},
        '{we:1'b1, wa:5'd7,  wd:32'h0000_00B2, ra:5'd3,  rb:5'd7,  ea:32'h0000_00A1, eb:32'h0000_00B2, req:8'd1},
        '{we:1'b0, wa:5'd3,  wd:32'hFFFF_FFFF, ra:5'd3,  rb:5'd3,  ea:32'h0000_00A1, eb:32'h0000_00A1, req:8'd3},
        '{we:1'b1, wa:5'd0,  wd:32'hDEAD_BEEF, ra:5'd0,  rb:5'd0,  ea:32'h0, eb:32'h0, req:8'd5},
        '{we:1'b1, wa:5'd31, wd:32'hC3C3_0031, ra:5'd31, rb:5'd7,  ea:32'hC3C3_0031, eb:32'h0000_00B2, req:8'd4},
        '{we:1'b0, wa:5'd31, wd:32'h1234_5678, ra:5'd0,  rb:5'd31, ea:32'h0, eb:32'hC3C3_0031, req:8'd2},
        '{we:1'b1, wa:5'd3,  wd:32'h0000_00D4, ra:5'd7,  rb:5'd3,  ea:32'h0000_00B2, eb:32'h0000_00D4, req:8'd4},
        '{we:1'b0, wa:5'd3,  wd:32'h0,         ra:5'd3,  rb:5'd3,  ea:32'h0000_00D4, eb:32'h0000_00D4, req:8'd6}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string rtag(input logic [7:0] n);
        case (n)
            8'd1: return "R1";
            8'd2: return "R2";
            8'd3: return "R3";
            8'd4: return "R4";
            8'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #40000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state: entry zero reads zero on both ports (R5)
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R5 reset port a", rd_data_a, 32'h0);
        check("R5 reset port b", rd_data_b, 32'h0);
        rst_n = 1'b1;

        // Table walk: inputs set at negedge, outputs sampled 1 ns later
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wr_en = TBL[i].we; wr_addr = TBL[i].wa; wr_data = TBL[i].wd;
            rd_addr_a = TBL[i].ra; rd_addr_b = TBL[i].rb;
            #1;
            check({rtag(TBL[i].req), " table a"}, rd_data_a, TBL[i].ea);
            check({rtag(TBL[i].req), " table b"}, rd_data_b, TBL[i].eb);
        end

        // R7: fill every nonzero entry, then read all back on both ports
        for (int a = 1; a < 32; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(a); wr_data = 32'h5A00_0000 | (a * 32'h0001_0101);
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            rd_addr_a = 5'(a); rd_addr_b = 5'(31 - a);
            #1;
            check("R7 sweep a", rd_data_a, (a == 0) ? 32'h0 : (32'h5A00_0000 | (a * 32'h0001_0101)));
            check("R1 sweep b", rd_data_b, (a == 31) ? 32'h0 : (32'h5A00_0000 | ((31 - a) * 32'h0001_0101)));
        end

        // R8: write during reset is blocked and not passed through
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h9999_9999;
        rd_addr_a = 5'd9; rd_addr_b = 5'd10;
        #1;
        check("R8 no thru in reset", rd_data_a, 32'h5A00_0000 | (9 * 32'h0001_0101));
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        #1;
        check("R8 kept after reset", rd_data_a, 32'h5A00_0000 | (9 * 32'h0001_0101));
        check("R7 neighbour kept", rd_data_b, 32'h5A00_0000 | (10 * 32'h0001_0101));

        // R5: write to entry zero then read it next cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hFFFF_FFFF;
        rd_addr_a = 5'd0; rd_addr_b = 5'd0;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R5 zero after write", rd_data_a, 32'h0);

        // R2 then R3: store, hold with enable low, data changing
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'hCAFE_0012;
        rd_addr_a = 5'd1; rd_addr_b = 5'd1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'h0BAD_0BAD;
        rd_addr_a = 5'd12; rd_addr_b = 5'd12;
        #1;
        check("R2 stored", rd_data_a, 32'hCAFE_0012);
        @(negedge clk);
        #1;
        check("R3 held", rd_data_a, 32'hCAFE_0012);
        check("R6 same addr", rd_data_b, 32'hCAFE_0012);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule